// File: doc/BRIEF.md
# Calendar Clock Register Interface

This block keeps a binary calendar (seconds, minutes, hours, weekday, day of month, month and year) and exposes it through two byte ports. Software first writes a register number into the index port, then strobes a read of the data port. One cycle later the block returns one of two things. It returns a time field, or it returns one of three control registers whose contents are mostly constant. The calendar starts from values given as parameters and advances once per second, which the block derives from its own clock.

The data port can only be read. Writing to it, or reading a register number that the block does not serve, raises a one-cycle error pulse. The unserved numbers include the alarm slots, the fourth control register and everything above it.

A second, independent counter produces a one-cycle interrupt request at a fixed period. This counter runs freely and no register gates it. An upstream interrupt aggregator consumes the pulse.

Top module: `cal_clock_regs`

## Requirements
- R1: A byte written with `idx_we` selects the register. A `dat_re` strobe returns that register on `rd_data` with `rd_valid` high for exactly one cycle, on the cycle after the strobe. Time fields sit at index 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x06 (weekday 0..6), 0x07 (day of month 1..31), 0x08 (month) and 0x09 (year).
- R2: Index 0x0A returns the low seven bits 0x26 with an update flag in bit 7. The flag is 1 after reset and inverts after every successful read of index 0x0A.
- R3: Index 0x0B always returns 0x46 and index 0x0C always returns 0x00.
- R4: The month is returned 1-based (January = 1). The year is stored as years since 1900 and is returned as the stored value minus 52.
- R5: A `dat_we` strobe pulses `err` on the next cycle with `rd_valid` low. It changes neither the selected index nor the update flag.
- R6: A read of index 0x0D, of an alarm slot (0x01, 0x03, 0x05), or of any index above 0x0D pulses `err` with `rd_valid` low and `rd_data` 0x00, and leaves the update flag unchanged.
- R7: `tick_irq` is a one-cycle pulse that first appears TICK_PERIOD cycles after reset and then repeats every TICK_PERIOD cycles.
- R8: Seconds advance once every SEC_CYCLES cycles. Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0, each carrying into the next field.
- R9: At midnight the weekday wraps from 6 to 0. The day of month wraps to 1 after the last day of the month, and December wraps to January with the year incremented.
- R10: February has 29 days in years divisible by 4, except century years that are not divisible by 400 (full year = 1900 + stored year).
- R11: During and right after reset, `rd_valid`, `err` and `tick_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Write strobe for the index port |
| dat_we | input | 1 | Write strobe for the data port (unsupported, flags error) |
| dat_re | input | 1 | Read strobe for the data port |
| wdata | input | 8 | Write data byte for either port |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle qualifier for rd_data |
| err | output | 1 | One-cycle error pulse |
| tick_irq | output | 1 | Periodic one-cycle interrupt request |

## Verification
The assertions watch several properties on every cycle. They check the exact spacing and width of the periodic pulse, and that every data write produces an error pulse. They check that a valid result always follows a read strobe and never coincides with an error, and that control registers A and B give their values, including the alternation of the update flag. Some behaviour shows only in the bench's scenarios, because it needs particular starting dates and waits across second boundaries. This includes the calendar carry chain across midnight, month end and year end, the leap-year rule including the century exception, the month and year offsets, and the error reads of unserved indices.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] IX_SEC  = 8'h00;
  localparam logic [BYTE_W-1:0] IX_MIN  = 8'h02;
  localparam logic [BYTE_W-1:0] IX_HOUR = 8'h04;
  localparam logic [BYTE_W-1:0] IX_DOW  = 8'h06;
  localparam logic [BYTE_W-1:0] IX_DOM  = 8'h07;
  localparam logic [BYTE_W-1:0] IX_MON  = 8'h08;
  localparam logic [BYTE_W-1:0] IX_YEAR = 8'h09;
  localparam logic [BYTE_W-1:0] IX_CTLA = 8'h0A;
  localparam logic [BYTE_W-1:0] IX_CTLB = 8'h0B;
  localparam logic [BYTE_W-1:0] IX_CTLC = 8'h0C;

  localparam logic [6:0]        CTLA_LOW  = 7'h26;
  localparam logic [BYTE_W-1:0] CTLB_VAL  = 8'h46;
  localparam logic [BYTE_W-1:0] CTLC_VAL  = 8'h00;
  localparam logic [BYTE_W-1:0] YEAR_BIAS = 8'd52;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [3:0] mon;   // 0 = January
    logic [7:0] year;  // years since 1900
  } cc_time_t;

  function automatic logic is_leap(input logic [7:0] yr);
    logic [11:0] full;
    full = 12'd1900 + {4'd0, yr};
    return ((full[1:0] == 2'd0) && ((full % 12'd100) != 12'd0)) ||
           ((full % 12'd400) == 12'd0);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd1:                      return leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cc_tick_gen.sv
module cc_tick_gen #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + CW'(1);
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_calendar.sv
module cc_calendar
  import cc_pkg::*;
#(
  parameter int       SEC_CYCLES = 50_000_000,
  parameter cc_time_t INIT       = '0
) (
  input  logic     clk,
  input  logic     rst,
  output cc_time_t now
);
  logic     sec_tick;
  cc_time_t nxt;
  logic     leap;
  logic [4:0] mlen;

  cc_tick_gen #(.PERIOD(SEC_CYCLES)) u_sec (
    .clk   (clk),
    .rst   (rst),
    .pulse (sec_tick)
  );

  always_comb begin
    leap = is_leap(now.year);
    mlen = month_len(now.mon, leap);
    nxt  = now;
    if (now.sec != 6'd59) begin
      nxt.sec = now.sec + 6'd1;
    end else begin
      nxt.sec = 6'd0;
      if (now.min != 6'd59) begin
        nxt.min = now.min + 6'd1;
      end else begin
        nxt.min = 6'd0;
        if (now.hour != 5'd23) begin
          nxt.hour = now.hour + 5'd1;
        end else begin
          nxt.hour = 5'd0;
          nxt.dow  = (now.dow == 3'd6) ? 3'd0 : now.dow + 3'd1;
          if (now.dom != mlen) begin
            nxt.dom = now.dom + 5'd1;
          end else begin
            nxt.dom = 5'd1;
            if (now.mon != 4'd11) begin
              nxt.mon = now.mon + 4'd1;
            end else begin
              nxt.mon  = 4'd0;
              nxt.year = now.year + 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           now <= INIT;
    else if (sec_tick) now <= nxt;
  end
endmodule

// File: rtl/cc_reg_read.sv
module cc_reg_read
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic              dat_re,
  input  logic [BYTE_W-1:0] wdata,
  input  cc_time_t          now,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err
);
  logic [BYTE_W-1:0] idx_q;
  logic              uip_q;
  logic              hit;
  logic [BYTE_W-1:0] val;

  always_comb begin
    hit = 1'b1;
    val = '0;
    case (idx_q)
      IX_SEC:  val = {2'd0, now.sec};
      IX_MIN:  val = {2'd0, now.min};
      IX_HOUR: val = {3'd0, now.hour};
      IX_DOW:  val = {5'd0, now.dow};
      IX_DOM:  val = {3'd0, now.dom};
      IX_MON:  val = {4'd0, now.mon} + 8'd1;
      IX_YEAR: val = now.year - YEAR_BIAS;
      IX_CTLA: val = {uip_q, CTLA_LOW};
      IX_CTLB: val = CTLB_VAL;
      IX_CTLC: val = CTLC_VAL;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      uip_q    <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      if (idx_we) idx_q <= wdata;
      if (dat_we) begin
        err <= 1'b1;
      end else if (dat_re) begin
        if (hit) begin
          rd_valid <= 1'b1;
          rd_data  <= val;
          if (idx_q == IX_CTLA) uip_q <= ~uip_q;
        end else begin
          err     <= 1'b1;
          rd_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cal_clock_regs.sv
module cal_clock_regs
  import cc_pkg::*;
#(
  parameter int TICK_PERIOD = 1_000_000,
  parameter int SEC_CYCLES  = 50_000_000,
  parameter int INIT_SEC    = 0,
  parameter int INIT_MIN    = 0,
  parameter int INIT_HOUR   = 0,
  parameter int INIT_DOW    = 4,
  parameter int INIT_DOM    = 1,
  parameter int INIT_MON    = 1,   // 1..12
  parameter int INIT_YEAR   = 70   // years since 1900
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic       dat_re,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       err,
  output logic       tick_irq
);
  localparam cc_time_t INIT_T = '{
    sec:  6'(INIT_SEC),
    min:  6'(INIT_MIN),
    hour: 5'(INIT_HOUR),
    dow:  3'(INIT_DOW),
    dom:  5'(INIT_DOM),
    mon:  4'(INIT_MON - 1),
    year: 8'(INIT_YEAR)
  };

  cc_time_t now;

  cc_calendar #(.SEC_CYCLES(SEC_CYCLES), .INIT(INIT_T)) u_cal (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  cc_reg_read u_regs (
    .clk      (clk),
    .rst      (rst),
    .idx_we   (idx_we),
    .dat_we   (dat_we),
    .dat_re   (dat_re),
    .wdata    (wdata),
    .now      (now),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .err      (err)
  );

  cc_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .pulse (tick_irq)
  );
endmodule

// File: rtl/cal_clock_regs_chk.sv
module cal_clock_regs_chk #(
  parameter int TICK_PERIOD = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       idx_we,
  input logic       dat_we,
  input logic       dat_re,
  input logic [7:0] wdata,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       err,
  input logic       tick_irq
);
  logic [31:0] gap;
  logic [7:0]  sel_q;
  logic [7:0]  rd_idx;
  logic        exp_uip;
  logic        was_a;
  logic        was_b;

  assign was_a = (rd_idx == 8'h0A);
  assign was_b = (rd_idx == 8'h0B);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      sel_q   <= '0;
      rd_idx  <= '0;
      exp_uip <= 1'b1;
    end else begin
      gap <= tick_irq ? 32'd1 : gap + 32'd1;
      if (idx_we) sel_q <= wdata;
      if (dat_re) rd_idx <= sel_q;
      if (rd_valid && was_a) exp_uip <= ~exp_uip;
    end
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> gap == 32'(TICK_PERIOD));

  // R7
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick_irq |=> !tick_irq);

  // R5
  wr_err_chk: assert property (@(posedge clk) disable iff (rst)
    dat_we |=> (err && !rd_valid));

  // R1
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(dat_re));

  // R6
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err && rd_valid));

  // R2
  ctla_uip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && was_a) |-> rd_data == {exp_uip, 7'h26});

  // R3
  ctlb_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && was_b) |-> rd_data == 8'h46);
endmodule

bind cal_clock_regs cal_clock_regs_chk #(.TICK_PERIOD(TICK_PERIOD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .idx_we   (idx_we),
  .dat_we   (dat_we),
  .dat_re   (dat_re),
  .wdata    (wdata),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .err      (err),
  .tick_irq (tick_irq)
);

// File: tb/test_cal_clock_regs.sv
`timescale 1ns/1ps
module test_cal_clock_regs;
  localparam int TP  = 12;
  localparam int SEC = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] d0, d1, d2;
  logic       v0, v1, v2, e0, e1, e2, t0, t1, t2;
  int         cyc = 0;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  cal_clock_regs #(.TICK_PERIOD(TP), .SEC_CYCLES(SEC), .INIT_SEC(58), .INIT_MIN(59),
    .INIT_HOUR(23), .INIT_DOW(6), .INIT_DOM(31), .INIT_MON(12), .INIT_YEAR(99)) i_cal_clock_regs (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re), .wdata(wdata),
    .rd_data(d0), .rd_valid(v0), .err(e0), .tick_irq(t0));

  cal_clock_regs #(.TICK_PERIOD(TP), .SEC_CYCLES(SEC), .INIT_SEC(59), .INIT_MIN(59),
    .INIT_HOUR(23), .INIT_DOW(1), .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(100)) i_leap (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re), .wdata(wdata),
    .rd_data(d1), .rd_valid(v1), .err(e1), .tick_irq(t1));

  cal_clock_regs #(.TICK_PERIOD(TP), .SEC_CYCLES(SEC), .INIT_SEC(59), .INIT_MIN(59),
    .INIT_HOUR(23), .INIT_DOW(0), .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(200)) i_noleap (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re), .wdata(wdata),
    .rd_data(d2), .rd_valid(v2), .err(e2), .tick_irq(t2));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic rd_cur();
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ix);
    @(negedge clk); idx_we = 1'b1; wdata = ix;
    @(negedge clk); idx_we = 1'b0; dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0;
  endtask

  task automatic rd_field(input string req, input logic [7:0] ix, input logic [7:0] exp);
    rd(ix);
    chk(req, d0, exp);
    chk(req, {7'd0, v0}, 8'd1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 rd_valid", {7'd0, v0}, 8'd0);
    chk("R11 err", {7'd0, e0}, 8'd0);
    chk("R11 tick_irq", {7'd0, t0}, 8'd0);
    rst = 1'b0;
  endtask

  task automatic t_tick();
    while (cyc < 2 * TP + 1) begin
      @(negedge clk);
      chk("R7 tick pulse", {7'd0, t0}, {7'd0, (cyc == TP) || (cyc == 2 * TP)});
    end
  endtask

  task automatic t_init_fields();
    rd_field("R1 seconds", 8'h00, 8'd58);
    rd_field("R1 minutes", 8'h02, 8'd59);
    rd_field("R1 hours",   8'h04, 8'd23);
    rd_field("R1 weekday", 8'h06, 8'd6);
    rd_field("R1 day",     8'h07, 8'd31);
    rd_field("R4 month",   8'h08, 8'd12);
    rd_field("R4 year",    8'h09, 8'd47);
  endtask

  task automatic t_ctrl();
    rd_field("R2 ctlA first", 8'h0A, 8'hA6);
    rd_field("R3 ctlB",       8'h0B, 8'h46);
    rd_field("R3 ctlC",       8'h0C, 8'h00);
    rd_field("R2 ctlA second", 8'h0A, 8'h26);
  endtask

  task automatic t_errors();
    logic [7:0] bad [3];
    bad[0] = 8'h0D; bad[1] = 8'h01; bad[2] = 8'h20;
    for (int i = 0; i < 3; i++) begin
      rd(bad[i]);
      chk("R6 err", {7'd0, e0}, 8'd1);
      chk("R6 rd_valid", {7'd0, v0}, 8'd0);
      chk("R6 rd_data", d0, 8'h00);
    end
    rd_field("R6 ctlA flag unchanged", 8'h0A, 8'hA6);
    rd_field("R3 ctlB select", 8'h0B, 8'h46);
    @(negedge clk); dat_we = 1'b1; wdata = 8'h0A;
    @(negedge clk); dat_we = 1'b0;
    chk("R5 err", {7'd0, e0}, 8'd1);
    chk("R5 rd_valid", {7'd0, v0}, 8'd0);
    rd_cur();
    chk("R5 index kept", d0, 8'h46);
    rd_field("R5 ctlA flag kept", 8'h0A, 8'h26);
  endtask

  task automatic t_first_second();
    wait (cyc >= SEC + 2);
    rd_field("R8 seconds advance", 8'h00, 8'd59);
    rd_field("R8 minutes held", 8'h02, 8'd59);
    rd(8'h07);
    chk("R10 leap Feb 29", d1, 8'd29);
    chk("R9 non-leap Mar 1", d2, 8'd1);
  endtask

  task automatic t_rollover();
    wait (cyc >= 2 * SEC + 5);
    rd(8'h00);
    chk("R8 sec wrap", d0, 8'd0);  chk("R8 sec leap", d1, 8'd1);
    rd(8'h02); chk("R8 min wrap", d0, 8'd0);
    rd(8'h04);
    chk("R8 hour wrap", d0, 8'd0); chk("R8 hour leap", d1, 8'd0);
    rd(8'h06);
    chk("R9 weekday wrap", d0, 8'd0);
    chk("R9 weekday leap", d1, 8'd2); chk("R9 weekday noleap", d2, 8'd1);
    rd(8'h07);
    chk("R9 day wrap", d0, 8'd1); chk("R10 leap day", d1, 8'd29);
    chk("R10 century day", d2, 8'd1);
    rd(8'h08);
    chk("R9 month wrap", d0, 8'd1); chk("R4 month leap", d1, 8'd2);
    chk("R10 century month", d2, 8'd3);
    rd(8'h09);
    chk("R9 year inc", d0, 8'd48); chk("R4 year leap", d1, 8'd48);
    chk("R4 year noleap", d2, 8'd148);
  endtask

  initial begin
    t_reset();
    t_tick();
    t_init_fields();
    t_ctrl();
    t_errors();
    t_first_second();
    t_rollover();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule